// File: doc/BRIEF.md
# CSR Access Permission Checker

This block decides, in the same cycle as the request, whether an access to a control and status register (CSR) must be turned into an illegal-instruction exception. It takes the 12-bit CSR address, a flag that says whether the access writes, and the hart's current privilege level. It combines them with a mode configuration that says which privilege levels exist on the hart.

The mode configuration is sampled while reset is held and then stays fixed. It selects one of three hart shapes: machine only, machine plus user, or machine plus supervisor plus user. An undefined configuration code falls back to machine only. When supervisor mode is absent, supervisor-level CSRs and the two machine delegation registers become illegal. The block also drives the user and supervisor extension bits for the ISA description register. In addition, it flags an address that belongs to the supervisor-only delegation set, so that the neighbouring CSR file can steer those accesses.

Top module: `csr_access_checker`

## Requirements
- R1: The lowest privilege allowed to touch a CSR is address bits [9:8]. An access is illegal when the current privilege is numerically below that value. A level-2 (hypervisor-range) CSR accessed from machine level is therefore legal.
- R2: When address bits [11:10] are 2'b11 the CSR is read-only. A write to it is illegal, and a read is governed only by the other rules.
- R3: When supervisor mode is not configured, any access to a CSR with address bits [9:8] = 2'b01 is illegal.
- R4: `deleg_csr_o` is high exactly for addresses 0x302 and 0x303, whatever the configuration. When supervisor mode is not configured, any read or write of those two addresses is illegal.
- R5: The configuration codes are 2'b00 machine only, 2'b01 machine+user, and 2'b10 machine+supervisor+user. Code 2'b11 is treated as machine only. The code is captured on each clock edge while `rst_n` is low, and changes after reset have no effect.
- R6: `misa_modes_o` bit 20 is set when user mode is configured, and bit 18 is set when supervisor mode is configured. All other bits are zero. Supervisor is never advertised without user.
- R7: The privilege encoding is user=0, supervisor=1, machine=3, and 2 is reserved. Any access from a reserved level, or from a level that the configuration does not implement, is illegal.
- R8: `illegal_o` and `deleg_csr_o` are combinational and valid in the same cycle as the inputs. An access that breaks none of R1 to R4 and R7 is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Active-low synchronous reset; configuration is captured while low |
| mode_cfg_i | input | 2 | Requested privilege-mode configuration code |
| csr_addr_i | input | 12 | CSR address of the access |
| csr_we_i | input | 1 | High when the access writes the CSR |
| cur_priv_i | input | 2 | Current privilege level |
| illegal_o | output | 1 | Access must raise an illegal-instruction exception |
| deleg_csr_o | output | 1 | Address is one of the delegation registers |
| misa_modes_o | output | 26 | Mode-support bits for the ISA description register |

## Verification
The main decision is swept over a grid for each of the three legal configurations. The grid covers every privilege value (including the reserved one), both read and write, and addresses chosen to tell the rules apart: user read/write, user read-only, supervisor, hypervisor-range, machine read/write, machine read-only, the two delegation registers and their neighbours. The neighbours 0x301 and 0x304 separate an exact delegation match from a coarse range match. The read-only machine address probes the write rule separately from the privilege rule. The undefined configuration code is checked to fall back to machine only. A configuration change made after reset is checked to leave both the advertised bits and the decisions unchanged.

// File: rtl/csr_chk_pkg.sv
package csr_chk_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    CFG_M_ONLY = 2'd0,
    CFG_M_U    = 2'd1,
    CFG_M_S_U  = 2'd2,
    CFG_UNDEF  = 2'd3
  } mode_cfg_e;

  typedef struct packed {
    logic u_en;
    logic s_en;
  } mode_set_t;

  typedef struct packed {
    logic [1:0] min_priv;
    logic       read_only;
    logic       deleg;
  } csr_attr_t;

  // Undefined codes collapse to machine only; supervisor always brings user.
  function automatic mode_set_t decode_cfg(input logic [1:0] code);
    mode_set_t m;
    case (mode_cfg_e'(code))
      CFG_M_U:   begin m.u_en = 1'b1; m.s_en = 1'b0; end
      CFG_M_S_U: begin m.u_en = 1'b1; m.s_en = 1'b1; end
      default:   begin m.u_en = 1'b0; m.s_en = 1'b0; end
    endcase
    return m;
  endfunction

endpackage

// File: rtl/csr_mode_cfg.sv
module csr_mode_cfg
  import csr_chk_pkg::*;
#(
  parameter int MISA_W = 26,
  parameter int U_BIT  = 20,
  parameter int S_BIT  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_i,
  output mode_set_t         modes_o,
  output logic [MISA_W-1:0] misa_o
);

  mode_set_t modes_q;

  // Configuration is loaded only while reset is held, then frozen.
  always_ff @(posedge clk) begin
    if (!rst_n) modes_q <= decode_cfg(cfg_i);
  end

  assign modes_o = modes_q;

  for (genvar b = 0; b < MISA_W; b++) begin : g_misa
    if (b == U_BIT) begin : g_u
      assign misa_o[b] = modes_q.u_en;
    end else if (b == S_BIT) begin : g_s
      assign misa_o[b] = modes_q.s_en;
    end else begin : g_zero
      assign misa_o[b] = 1'b0;
    end
  end

  // R6: supervisor is never advertised without user
  p_s_needs_u_r6: assert property (@(posedge clk) disable iff (!rst_n)
    misa_o[S_BIT] |-> misa_o[U_BIT]);

  // R5: frozen configuration after reset
  p_cfg_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(misa_o));

endmodule

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
  import csr_chk_pkg::*;
#(
  parameter int              ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] DELEG_BASE = 12'h302,
  parameter int              DELEG_COUNT = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output csr_attr_t         attr_o
);

  localparam int PRIV_LSB = ADDR_W - 4;
  localparam int RO_LSB   = ADDR_W - 2;

  logic [DELEG_COUNT-1:0] hit;

  for (genvar i = 0; i < DELEG_COUNT; i++) begin : g_deleg
    localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(DELEG_BASE + i);
    assign hit[i] = (addr_i == SLOT);
  end

  assign attr_o.min_priv  = addr_i[PRIV_LSB +: 2];
  assign attr_o.read_only = (addr_i[RO_LSB +: 2] == 2'b11);
  assign attr_o.deleg     = |hit;

endmodule

// File: rtl/csr_priv_gate.sv
module csr_priv_gate
  import csr_chk_pkg::*;
(
  input  csr_attr_t  attr_i,
  input  mode_set_t  modes_i,
  input  logic       we_i,
  input  logic [1:0] priv_i,
  output logic       illegal_o
);

  logic level_ok;
  logic ro_fault;
  logic rank_fault;
  logic smode_fault;

  always_comb begin
    case (priv_e'(priv_i))
      PRIV_M:  level_ok = 1'b1;
      PRIV_S:  level_ok = modes_i.s_en;
      PRIV_U:  level_ok = modes_i.u_en;
      default: level_ok = 1'b0;
    endcase
  end

  assign ro_fault    = we_i & attr_i.read_only;
  assign rank_fault  = (priv_i < attr_i.min_priv);
  assign smode_fault = ~modes_i.s_en &
                       ((attr_i.min_priv == PRIV_S) | attr_i.deleg);

  assign illegal_o = ~level_ok | ro_fault | rank_fault | smode_fault;

endmodule

// File: rtl/csr_access_checker.sv
module csr_access_checker
  import csr_chk_pkg::*;
#(
  parameter int                ADDR_W      = 12,
  parameter int                MISA_W      = 26,
  parameter int                U_BIT       = 20,
  parameter int                S_BIT       = 18,
  parameter logic [ADDR_W-1:0] DELEG_BASE  = 12'h302,
  parameter int                DELEG_COUNT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_cfg_i,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic              csr_we_i,
  input  logic [1:0]        cur_priv_i,
  output logic              illegal_o,
  output logic              deleg_csr_o,
  output logic [MISA_W-1:0] misa_modes_o
);

  localparam int PRIV_LSB = ADDR_W - 4;
  localparam int RO_LSB   = ADDR_W - 2;

  mode_set_t modes;
  csr_attr_t attr;

  csr_mode_cfg #(.MISA_W(MISA_W), .U_BIT(U_BIT), .S_BIT(S_BIT)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_i   (mode_cfg_i),
    .modes_o (modes),
    .misa_o  (misa_modes_o)
  );

  csr_addr_decode #(.ADDR_W(ADDR_W), .DELEG_BASE(DELEG_BASE),
                    .DELEG_COUNT(DELEG_COUNT)) u_dec (
    .addr_i (csr_addr_i),
    .attr_o (attr)
  );

  csr_priv_gate u_gate (
    .attr_i    (attr),
    .modes_i   (modes),
    .we_i      (csr_we_i),
    .priv_i    (cur_priv_i),
    .illegal_o (illegal_o)
  );

  assign deleg_csr_o = attr.deleg;

  // R1: too low a privilege always faults
  p_rank_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_priv_i < csr_addr_i[PRIV_LSB +: 2]) |-> illegal_o);

  // R2: writes to read-only space always fault
  p_ro_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we_i && csr_addr_i[RO_LSB +: 2] == 2'b11) |-> illegal_o);

  // R3: supervisor CSRs fault when supervisor is not advertised
  p_no_smode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!misa_modes_o[S_BIT] && csr_addr_i[PRIV_LSB +: 2] == 2'b01) |-> illegal_o);

  // R4: delegation registers fault when supervisor is not advertised
  p_deleg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (deleg_csr_o && !misa_modes_o[S_BIT]) |-> illegal_o);

  // R7: reserved current level always faults
  p_rsv_priv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_priv_i == 2'd2) |-> illegal_o);

endmodule

// File: tb/csr_access_checker_tb.sv
`timescale 1ns/1ps
module csr_access_checker_tb;

  typedef struct {
    logic        ill;
    logic        dl;
    string       tag;
    logic [11:0] addr;
    logic [1:0]  priv;
    logic        we;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_cfg_i = 2'd0;
  logic [11:0] csr_addr_i = 12'h000;
  logic        csr_we_i = 1'b0;
  logic [1:0]  cur_priv_i = 2'd3;
  logic        illegal_o;
  logic        deleg_csr_o;
  logic [25:0] misa_modes_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  csr_access_checker u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_cfg_i   (mode_cfg_i),
    .csr_addr_i   (csr_addr_i),
    .csr_we_i     (csr_we_i),
    .cur_priv_i   (cur_priv_i),
    .illegal_o    (illegal_o),
    .deleg_csr_o  (deleg_csr_o),
    .misa_modes_o (misa_modes_o)
  );

  function automatic void model(input logic [1:0] cfg, input logic [11:0] a,
                                input logic we, input logic [1:0] p,
                                output logic ill, output logic dl, output string tag);
    logic s_en, u_en;
    s_en = (cfg == 2'd2);
    u_en = (cfg == 2'd1) || (cfg == 2'd2);
    dl   = (a == 12'h302) || (a == 12'h303);
    ill  = 1'b1;
    if (p == 2'd2 || (p == 2'd1 && !s_en) || (p == 2'd0 && !u_en)) tag = "R7";
    else if (we && a[11:10] == 2'b11)                               tag = "R2";
    else if (p < a[9:8])                                             tag = "R1";
    else if (a[9:8] == 2'b01 && !s_en)                               tag = "R3";
    else if (dl && !s_en)                                            tag = "R4";
    else begin ill = 1'b0; tag = "R8"; end
  endfunction

  function automatic logic [25:0] misa_model(input logic [1:0] cfg);
    logic [25:0] m = '0;
    if (cfg == 2'd1 || cfg == 2'd2) m[20] = 1'b1;
    if (cfg == 2'd2) m[18] = 1'b1;
    return m;
  endfunction

  // Monitor: compares half a cycle after each drive.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks += 2;
      if (illegal_o !== e.ill) begin
        errors++;
        $display("FAIL %s illegal addr=%h we=%0b priv=%0d: actual %0b expected %0b",
                 e.tag, e.addr, e.we, e.priv, illegal_o, e.ill);
      end
      if (deleg_csr_o !== e.dl) begin
        errors++;
        $display("FAIL R4 deleg addr=%h: actual %0b expected %0b",
                 e.addr, deleg_csr_o, e.dl);
      end
    end
  end

  task automatic drive(input logic [1:0] cfg_model, input logic [11:0] a,
                       input logic we, input logic [1:0] p);
    exp_t e;
    @(posedge clk);
    #1;
    csr_addr_i = a;
    csr_we_i   = we;
    cur_priv_i = p;
    model(cfg_model, a, we, p, e.ill, e.dl, e.tag);
    e.addr = a; e.we = we; e.priv = p;
    q.push_back(e);
  endtask

  task automatic check_misa(input logic [1:0] cfg_model, input string tag);
    logic [25:0] exp_m;
    exp_m = misa_model(cfg_model);
    checks++;
    if (misa_modes_o !== exp_m) begin
      errors++;
      $display("FAIL %s misa: actual %h expected %h", tag, misa_modes_o, exp_m);
    end
  endtask

  task automatic do_reset(input logic [1:0] code);
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    mode_cfg_i = code;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  logic [11:0] addrs [11] = '{12'h000, 12'hC00, 12'h100, 12'h180, 12'h200,
                              12'h300, 12'h301, 12'h302, 12'h303, 12'h304, 12'hF14};

  task automatic sweep(input logic [1:0] cfg_model);
    for (int a = 0; a < 11; a++)
      for (int p = 0; p < 4; p++)
        for (int w = 0; w < 2; w++)
          drive(cfg_model, addrs[a], w[0], p[1:0]);
  endtask

  initial begin
    // R5: undefined code clamps to machine only; R6 advertised bits
    do_reset(2'd3);
    check_misa(2'd0, "R5");
    sweep(2'd0);

    do_reset(2'd0);
    check_misa(2'd0, "R6");
    sweep(2'd0);

    do_reset(2'd1);
    check_misa(2'd1, "R6");
    sweep(2'd1);

    do_reset(2'd2);
    check_misa(2'd2, "R6");
    sweep(2'd2);

    // R5: a change after reset has no effect
    @(posedge clk);
    #1;
    mode_cfg_i = 2'd0;
    repeat (3) @(posedge clk);
    #1;
    check_misa(2'd2, "R5");
    drive(2'd2, 12'h100, 1'b0, 2'd1);
    drive(2'd2, 12'h302, 1'b1, 2'd3);

    while (q.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule